// File: doc/BRIEF.md
# JTAG Instruction and Test Data Register Core

This block sits behind a separate TAP state machine and holds everything the test port needs once the state has been decoded. The state machine supplies one strobe per relevant state (test-logic-reset, capture/shift/update for the instruction path and capture/shift/update for the data path). The block keeps a 3-bit instruction register, a 1-bit bypass register and a 32-bit identification register, and decodes the active instruction. It uses that decode to pick the register that feeds the serial output and to set the pad-control signals for the rest of the chip.

The boundary-scan cell chain lives outside the block. The chain takes its serial input from `bs_si` and returns its last cell on `bs_so`. It receives capture, shift and update strobes that are gated by the active instruction. Two registered pad controls go out to the I/O ring. `bs_drive` steers the pads to the chain's held parallel values. `pad_oe` enables the output drivers.

Top module: `jtag_tdr_core`

## Requirements
- R1: Synchronous reset and the test-logic-reset strobe both make IDCODE (3'b001) the active instruction. A data scan that follows reads the identification value without any instruction load.
- R2: Capture-IR loads 3'b001 into the instruction shift stage. During shift-IR that stage moves one bit toward the LSB per TCK, TDI enters at bit 2, and TDO presents bit 0.
- R3: The active instruction, and therefore every pad control and data-register selection, changes only on the update-IR edge, on reset, or on test-logic-reset. Shifting a new opcode without an update leaves all of them unchanged.
- R4: When IDCODE is active, capture-DR loads {rev[3:0], part[15:0], mfr[11:1], 1'b1}. With the defaults (rev 0, part 0x0090, mfr 0x143) this is 0x00090143. Shift-DR sends the value out LSB first while TDI fills from bit 31.
- R5: Opcodes 111 (BYPASS), 011 (CLAMP), 100 (HIGHZ) and the unassigned 101 and 110 select the 1-bit bypass register. It captures 0, and in shift-DR TDO shows the TDI of the previous shift cycle.
- R6: Opcodes 000 (EXTEST) and 010 (SAMPLE/PRELOAD) select the external chain, and TDO carries `bs_so` during shift-DR. `bs_capture`, `bs_shift` and `bs_update` follow the capture/shift/update-DR strobes only under these two opcodes and stay low otherwise, so CLAMP never disturbs the held chain values.
- R7: `bs_drive` is high exactly when the active opcode is 000 or 011. `pad_oe` is low exactly when it is 100. Both change on the same TCK rising edge that performs update-IR.
- R8: TDO and `tdo_oe` are registered on the falling TCK edge. `tdo_oe` is high only in the half-cycle after a falling edge that saw shift-IR or shift-DR.
- R9: During and right after reset, `pad_oe` is 1, `bs_drive` is 0 and `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| st_tlr | input | 1 | TAP is in test-logic-reset |
| st_cap_ir | input | 1 | TAP is in capture-IR |
| st_shf_ir | input | 1 | TAP is in shift-IR |
| st_upd_ir | input | 1 | TAP is in update-IR |
| st_cap_dr | input | 1 | TAP is in capture-DR |
| st_shf_dr | input | 1 | TAP is in shift-DR |
| st_upd_dr | input | 1 | TAP is in update-DR |
| tdi | input | 1 | Serial test data in |
| bs_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out (falling-edge register) |
| tdo_oe | output | 1 | Drive enable for TDO |
| bs_si | output | 1 | Serial input to the external boundary chain |
| bs_capture | output | 1 | Chain capture strobe |
| bs_shift | output | 1 | Chain shift strobe |
| bs_update | output | 1 | Chain parallel update strobe |
| bs_drive | output | 1 | Pads take their values from the chain's held parallel register |
| pad_oe | output | 1 | Pad output-driver enable |

## Verification
The bench goes after the unassigned opcodes 101 and 110. A decoder that let them fall into the chain or ID path would show `bs_so` or ID bits on TDO instead of the one-cycle-delayed TDI. It also shifts a new opcode and then enters test-logic-reset without an update. A design that copied the shift stage early would change the pad controls, and one that ignored the reset strobe would fail to read the ID. CLAMP is scanned with data-path strobes active to catch a chain update that leaks through and disturbs the held values. A 34-bit ID scan makes sure TDI really fills the ID register from the top and is not recirculated.

// File: rtl/jtag_tdr_pkg.sv
package jtag_tdr_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 3'b000,
    OP_IDCODE = 3'b001,
    OP_SAMPLE = 3'b010,
    OP_CLAMP  = 3'b011,
    OP_HIGHZ  = 3'b100,
    OP_BYPASS = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_IDENT  = 2'd1,
    DR_BSCAN  = 2'd2
  } dr_sel_e;

  typedef struct packed {
    logic    bs_drive;
    logic    pad_oe;
    dr_sel_e dr_sel;
  } ir_ctrl_t;

  // Unlisted opcodes fall to the bypass default.
  function automatic ir_ctrl_t decode_op(input logic [IR_W-1:0] op);
    ir_ctrl_t c;
    c = '{bs_drive: 1'b0, pad_oe: 1'b1, dr_sel: DR_BYPASS};
    case (op)
      OP_EXTEST: begin c.bs_drive = 1'b1; c.dr_sel = DR_BSCAN; end
      OP_SAMPLE: c.dr_sel = DR_BSCAN;
      OP_IDCODE: c.dr_sel = DR_IDENT;
      OP_CLAMP:  c.bs_drive = 1'b1;
      OP_HIGHZ:  c.pad_oe = 1'b0;
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_tdr_pkg::*;
(
  input  logic     tck,
  input  logic     rst,
  input  logic     st_tlr,
  input  logic     st_cap_ir,
  input  logic     st_shf_ir,
  input  logic     st_upd_ir,
  input  logic     tdi,
  output logic     ir_lsb,
  output ir_ctrl_t ctrl_q
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_act;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr <= '0;
    end else if (st_cap_ir) begin
      ir_sr <= CAP_PAT;
    end else if (st_shf_ir) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  // Active instruction and its registered decode move together.
  always_ff @(posedge tck) begin
    if (rst || st_tlr) begin
      ir_act <= OP_IDCODE;
      ctrl_q <= decode_op(OP_IDCODE);
    end else if (st_upd_ir) begin
      ir_act <= ir_sr;
      ctrl_q <= decode_op(ir_sr);
    end
  end

  assign ir_lsb = ir_sr[0];

  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (rst)
    st_tlr |=> (ir_act == OP_IDCODE)); // R1

  AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (rst)
    st_cap_ir |=> (ir_sr == CAP_PAT)); // R2

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (rst)
    (!st_upd_ir && !st_tlr) |=> $stable(ir_act)); // R3

endmodule

// File: rtl/jtag_id_reg.sv
module jtag_id_reg
  import jtag_tdr_pkg::*;
#(
  parameter logic [3:0]  ID_REV  = 4'h0,
  parameter logic [15:0] ID_PART = 16'h0090,
  parameter logic [11:0] ID_MFR  = 12'h143
) (
  input  logic tck,
  input  logic rst,
  input  logic sel,
  input  logic cap,
  input  logic shf,
  input  logic tdi,
  output logic lsb
);

  localparam logic [ID_W-1:0] ID_VALUE = {ID_REV, ID_PART, ID_MFR[11:1], 1'b1};

  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sr <= '0;
    end else if (sel && cap) begin
      id_sr <= ID_VALUE;
    end else if (sel && shf) begin
      id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  assign lsb = id_sr[0];

  AST_ID_LOAD: assert property (@(posedge tck) disable iff (rst)
    (sel && cap) |=> (id_sr == ID_VALUE)); // R4

endmodule

// File: rtl/jtag_bypass_reg.sv
module jtag_bypass_reg #(
  parameter int BYP_W = 1
) (
  input  logic tck,
  input  logic rst,
  input  logic cap,
  input  logic shf,
  input  logic tdi,
  output logic lsb
);

  logic [BYP_W-1:0] byp_q;

  generate
    if (BYP_W == 1) begin : g_single
      always_ff @(posedge tck) begin
        if (rst || cap) byp_q <= 1'b0;
        else if (shf)   byp_q <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck) begin
        if (rst || cap) byp_q <= '0;
        else if (shf)   byp_q <= {tdi, byp_q[BYP_W-1:1]};
      end
    end
  endgenerate

  assign lsb = byp_q[0];

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (rst)
    cap |=> (byp_q == '0)); // R5

endmodule

// File: rtl/jtag_tdr_core.sv
module jtag_tdr_core
  import jtag_tdr_pkg::*;
#(
  parameter logic [3:0]  ID_REV  = 4'h0,
  parameter logic [15:0] ID_PART = 16'h0090,
  parameter logic [11:0] ID_MFR  = 12'h143,
  parameter int          BYP_W   = 1
) (
  input  logic tck,
  input  logic rst,
  input  logic st_tlr,
  input  logic st_cap_ir,
  input  logic st_shf_ir,
  input  logic st_upd_ir,
  input  logic st_cap_dr,
  input  logic st_shf_dr,
  input  logic st_upd_dr,
  input  logic tdi,
  input  logic bs_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bs_si,
  output logic bs_capture,
  output logic bs_shift,
  output logic bs_update,
  output logic bs_drive,
  output logic pad_oe
);

  ir_ctrl_t ctrl;
  logic     ir_lsb;
  logic     id_lsb;
  logic     byp_lsb;
  logic     dr_lsb;
  logic     sel_id;
  logic     sel_bs;

  jtag_ir_unit u_ir (
    .tck       (tck),
    .rst       (rst),
    .st_tlr    (st_tlr),
    .st_cap_ir (st_cap_ir),
    .st_shf_ir (st_shf_ir),
    .st_upd_ir (st_upd_ir),
    .tdi       (tdi),
    .ir_lsb    (ir_lsb),
    .ctrl_q    (ctrl)
  );

  assign sel_id = (ctrl.dr_sel == DR_IDENT);
  assign sel_bs = (ctrl.dr_sel == DR_BSCAN);

  jtag_id_reg #(
    .ID_REV  (ID_REV),
    .ID_PART (ID_PART),
    .ID_MFR  (ID_MFR)
  ) u_id (
    .tck (tck),
    .rst (rst),
    .sel (sel_id),
    .cap (st_cap_dr),
    .shf (st_shf_dr),
    .tdi (tdi),
    .lsb (id_lsb)
  );

  jtag_bypass_reg #(.BYP_W(BYP_W)) u_byp (
    .tck (tck),
    .rst (rst),
    .cap (st_cap_dr),
    .shf (st_shf_dr),
    .tdi (tdi),
    .lsb (byp_lsb)
  );

  always_comb begin
    case (ctrl.dr_sel)
      DR_IDENT: dr_lsb = id_lsb;
      DR_BSCAN: dr_lsb = bs_so;
      default:  dr_lsb = byp_lsb;
    endcase
  end

  assign bs_si      = tdi;
  assign bs_capture = st_cap_dr && sel_bs;
  assign bs_shift   = st_shf_dr && sel_bs;
  assign bs_update  = st_upd_dr && sel_bs;
  assign bs_drive   = ctrl.bs_drive;
  assign pad_oe     = ctrl.pad_oe;

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= st_shf_ir || st_shf_dr;
      if (st_shf_ir)      tdo <= ir_lsb;
      else if (st_shf_dr) tdo <= dr_lsb;
    end
  end

  AST_TDO_OE_WINDOW: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (st_shf_ir || st_shf_dr)); // R8

  AST_HIGHZ_NO_DRIVE: assert property (@(posedge tck) disable iff (rst)
    !pad_oe |-> !bs_drive); // R7

endmodule

// File: tb/jtag_tdr_core_tb_top.sv
module jtag_tdr_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_ID = 32'h0009_0143;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic st_tlr = 0, st_cap_ir = 0, st_shf_ir = 0, st_upd_ir = 0;
  logic st_cap_dr = 0, st_shf_dr = 0, st_upd_dr = 0;
  logic tdi = 0, bs_so = 0;
  logic tdo, tdo_oe, bs_si, bs_capture, bs_shift, bs_update, bs_drive, pad_oe;

  jtag_tdr_core dut_i (
    .tck(tck), .rst(rst), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_shf_ir(st_shf_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_shf_dr(st_shf_dr), .st_upd_dr(st_upd_dr), .tdi(tdi), .bs_so(bs_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bs_si(bs_si), .bs_capture(bs_capture),
    .bs_shift(bs_shift), .bs_update(bs_update), .bs_drive(bs_drive),
    .pad_oe(pad_oe)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference state
  logic [2:0]  m_sr  = 3'd0;
  logic [2:0]  m_act = 3'd1;
  logic [31:0] m_id  = 32'd0;
  logic        m_bp  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic tlr, input logic cir, input logic sir,
                      input logic uir, input logic cdr, input logic sdr, input logic udr,
                      input logic ti);
    logic exp_oe, exp_tdo, chain;
    string dtag;
    @(posedge tck);
    #1;
    rst = r; st_tlr = tlr; st_cap_ir = cir; st_shf_ir = sir; st_upd_ir = uir;
    st_cap_dr = cdr; st_shf_dr = sdr; st_upd_dr = udr; tdi = ti;
    bs_so = cyc[0] ^ cyc[2];
    cyc++;
    #7;
    chain  = (m_act == 3'd0) || (m_act == 3'd2);
    exp_oe = !r && (sir || sdr);
    chk(r ? "R9 tdo_oe in reset" : "R8 tdo_oe", {31'd0, tdo_oe}, {31'd0, exp_oe});
    if (exp_oe) begin
      if (sir) begin
        exp_tdo = m_sr[0]; dtag = "R2 ir shift bit";
      end else if (m_act == 3'd1) begin
        exp_tdo = m_id[0]; dtag = "R1,R4 id bit";
      end else if (chain) begin
        exp_tdo = bs_so; dtag = "R6 chain bit";
      end else begin
        exp_tdo = m_bp; dtag = "R5 bypass bit";
      end
      chk(dtag, {31'd0, tdo}, {31'd0, exp_tdo});
    end
    chk(r ? "R9 bs_drive" : "R3,R7 bs_drive", {31'd0, bs_drive},
        {31'd0, (m_act == 3'd0) || (m_act == 3'd3)});
    chk(r ? "R9 pad_oe" : "R3,R7 pad_oe", {31'd0, pad_oe}, {31'd0, m_act != 3'd4});
    chk("R6 chain strobes", {29'd0, bs_capture, bs_shift, bs_update},
        {29'd0, cdr && chain, sdr && chain, udr && chain});
    chk("R6 chain serial in", {31'd0, bs_si}, {31'd0, ti});
    // advance the model to the next rising edge
    if (r) begin
      m_act = 3'd1; m_sr = 3'd0; m_id = 32'd0; m_bp = 1'b0;
    end else begin
      if (cdr) begin
        m_bp = 1'b0;
        if (m_act == 3'd1) m_id = EXP_ID;
      end else if (sdr) begin
        m_bp = ti;
        if (m_act == 3'd1) m_id = {ti, m_id[31:1]};
      end
      if (tlr) m_act = 3'd1;
      else if (uir) m_act = m_sr;
      if (cir) m_sr = 3'b001;
      else if (sir) m_sr = {ti, m_sr[2:1]};
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic shift_ir(input logic [2:0] op);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, 0, op[i]);
    idle();
  endtask

  task automatic load_ir(input logic [2:0] op);
    shift_ir(op);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle();
  endtask

  task automatic scan_dr(input int n, input logic [63:0] pat);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0, pat[i % 64]);
    idle();
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    scan_dr(32, 64'h0);                        // R1 ID after reset
    load_ir(3'b111); scan_dr(8, 64'hA5);       // R5 bypass
    load_ir(3'b101); scan_dr(6, 64'h2D);       // R5 unassigned
    load_ir(3'b110); scan_dr(6, 64'h13);       // R5 unassigned
    load_ir(3'b011); scan_dr(6, 64'h3C);       // R6,R7 clamp
    load_ir(3'b100); scan_dr(5, 64'h15);       // R7 highz
    load_ir(3'b000); scan_dr(12, 64'hF0F);     // R6 extest
    load_ir(3'b010); scan_dr(12, 64'h9A5);     // R6 sample
    load_ir(3'b001); scan_dr(34, 64'h3_DEAD_BEEF); // R4 tdi fill
    scan_dr(32, 64'h0);                        // R4 fresh capture
    load_ir(3'b111);
    shift_ir(3'b100);                          // R3 no update
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);           // R1 tlr
    idle();
    scan_dr(32, 64'h0);
    load_ir(3'b000);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);           // R9 reset mid-operation
    idle();
    scan_dr(32, 64'h0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule